// File: doc/BRIEF.md
# Stereo DC-Blocking Filter with Offset Hold

This block sits after decimation in a stereo capture path. It removes the slow DC component from a stream of two's-complement samples. Samples arrive one at a time, each with a strobe and a tag that says whether it is a left or a right sample. Each channel keeps its own running estimate of its DC level in a leaky integrator. The block subtracts that estimate from every sample of the channel and registers the result one clock later. If the difference does not fit the sample width, the result is clipped to the nearest end of the range rather than wrapping.

A hold input stops both estimates from moving while the subtraction goes on with the held values. This supports a system offset calibration. The filter first runs free long enough to settle, which takes on the order of 2^SHIFT_K times ln(2^DATA_W) samples. The hold is then raised, and whatever offset the whole upstream path has is removed from every later sample. Both stored estimates are visible at the ports at all times.

Top module: `dct_trim_filter`

## Requirements
- R1: While reset is low and after its release, out_valid is 0, out_data is 0 and both offset ports are 0, until the first input strobe.
- R2: Every cycle with in_valid high is followed, exactly one clock later, by a cycle with out_valid high, and out_chan then equals the in_chan that was sampled (0 = left, 1 = right). A cycle without in_valid is followed by out_valid low.
- R3: out_data equals the sampled in_data minus the stored estimate of the tagged channel as it stood before that sample's update, when that difference fits in DATA_W bits.
- R4: With hold low, a strobed sample x updates the tagged channel's accumulator A (signed, scaled by 2^SHIFT_K) to A + floor(((x·2^SHIFT_K) − A) / 2^SHIFT_K). The channel's offset port shows floor(A / 2^SHIFT_K).
- R5: A sample tagged for one channel leaves the other channel's offset port unchanged.
- R6: A strobed sample taken while hold is high leaves both offset ports unchanged.
- R7: While hold is high, out_data is still the sample minus the held estimate of its channel.
- R8: When the difference exceeds the signed DATA_W range, out_data is clipped to the most positive value (0x7FFFFF at 24 bits) or the most negative value (0x800000), whichever side it overflowed on.
- R9: In cycles without a strobe, both offset ports keep their values.
- R10: After a channel has been fed one constant value long enough unfrozen, the filtered output for that value is 0 or 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample strobe |
| in_chan | input | 1 | Channel tag: 0 left, 1 right |
| in_data | input | DATA_W | Two's-complement sample |
| freeze | input | 1 | Hold the DC estimates; subtraction continues |
| out_valid | output | 1 | Corrected sample strobe |
| out_chan | output | 1 | Channel tag of the corrected sample |
| out_data | output | DATA_W | Corrected, clipped sample |
| offset_left | output | DATA_W | Stored left DC estimate |
| offset_right | output | DATA_W | Stored right DC estimate |

## Verification
The bench builds the block with DATA_W of 24 and SHIFT_K of 4, so an estimate settles within a few hundred samples instead of hundreds of thousands. Because of that, full settling on a constant input and calibration followed by a hold both fit in a short run. It also makes it possible to drive an estimate to either end of the range and then feed the opposite extreme, which forces clipping on both sides. Random samples with random tags and occasional hold cycles are checked against an accumulator model kept in 64-bit integers in the bench.

// File: rtl/dct_pkg.sv
package dct_pkg;
  localparam int NUM_CH = 2;

  typedef enum logic {
    CH_LEFT  = 1'b0,
    CH_RIGHT = 1'b1
  } chan_e;
endpackage

// File: rtl/dct_track.sv
// One channel's leaky DC integrator. The accumulator holds the estimate
// scaled by 2^SHIFT_K, with one extra guard bit for the error term.
module dct_track #(
  parameter int DATA_W  = 24,
  parameter int SHIFT_K = 15
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     upd_en,
  input  logic signed [DATA_W-1:0] sample,
  output logic signed [DATA_W-1:0] est
);
  localparam int ACC_W = DATA_W + SHIFT_K + 1;
  localparam int ERR_W = ACC_W + 1;

  logic signed [ACC_W-1:0] acc_q;
  logic signed [ACC_W-1:0] acc_d;

  // acc + floor((x*2^K - acc) / 2^K)
  function automatic logic signed [ACC_W-1:0] leak_next(
    input logic signed [ACC_W-1:0]  a,
    input logic signed [DATA_W-1:0] x
  );
    logic signed [ERR_W-1:0] target;
    logic signed [ERR_W-1:0] err;
    logic signed [ERR_W-1:0] step;
    target = ERR_W'(x) <<< SHIFT_K;
    err    = target - ERR_W'(a);
    step   = err >>> SHIFT_K;
    return a + ACC_W'(step);
  endfunction

  assign acc_d = leak_next(acc_q, sample);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (upd_en) begin
      acc_q <= acc_d;
    end
  end

  assign est = DATA_W'(acc_q >>> SHIFT_K);
endmodule

// File: rtl/dct_sat_sub.sv
// Signed subtraction clipped to the DATA_W range.
module dct_sat_sub #(
  parameter int DATA_W = 24
) (
  input  logic signed [DATA_W-1:0] minuend,
  input  logic signed [DATA_W-1:0] subtrahend,
  output logic signed [DATA_W-1:0] result,
  output logic                     sat_hit
);
  localparam int WIDE_W = DATA_W + 1;
  localparam logic signed [DATA_W-1:0] MAXV = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic signed [DATA_W-1:0] MINV = {1'b1, {(DATA_W-1){1'b0}}};

  function automatic logic signed [DATA_W-1:0] clip(input logic signed [WIDE_W-1:0] w);
    if (w[DATA_W] == w[DATA_W-1]) return w[DATA_W-1:0];
    else if (w[DATA_W])           return MINV;
    else                          return MAXV;
  endfunction

  logic signed [WIDE_W-1:0] wide;

  assign wide    = WIDE_W'(minuend) - WIDE_W'(subtrahend);
  assign sat_hit = wide[DATA_W] ^ wide[DATA_W-1];
  assign result  = clip(wide);
endmodule

// File: rtl/dct_trim_filter.sv
module dct_trim_filter #(
  parameter int DATA_W  = 24,
  parameter int SHIFT_K = 15
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic                     in_chan,
  input  logic signed [DATA_W-1:0] in_data,
  input  logic                     freeze,
  output logic                     out_valid,
  output logic                     out_chan,
  output logic signed [DATA_W-1:0] out_data,
  output logic signed [DATA_W-1:0] offset_left,
  output logic signed [DATA_W-1:0] offset_right
);
  import dct_pkg::*;

  logic signed [DATA_W-1:0] est [NUM_CH];
  logic [NUM_CH-1:0]        ch_hit;
  logic [NUM_CH-1:0]        upd_en;
  logic signed [DATA_W-1:0] est_sel;
  logic signed [DATA_W-1:0] corr;
  logic                     sat_hit;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign ch_hit[c] = in_valid && (in_chan == 1'(c));
    // the hold gates only the estimate update, never the data path
    assign upd_en[c] = ch_hit[c] && !freeze;

    dct_track #(
      .DATA_W (DATA_W),
      .SHIFT_K(SHIFT_K)
    ) u_track (
      .clk   (clk),
      .rst_n (rst_n),
      .upd_en(upd_en[c]),
      .sample(in_data),
      .est   (est[c])
    );
  end

  assign est_sel = est[in_chan];

  dct_sat_sub #(
    .DATA_W(DATA_W)
  ) u_sub (
    .minuend   (in_data),
    .subtrahend(est_sel),
    .result    (corr),
    .sat_hit   (sat_hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_chan  <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_chan <= in_chan;
        out_data <= corr;
      end
    end
  end

  assign offset_left  = est[CH_LEFT];
  assign offset_right = est[CH_RIGHT];
endmodule

// File: rtl/dct_checker.sv
module dct_checker #(
  parameter int DATA_W = 24
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     in_valid,
  input logic                     in_chan,
  input logic                     freeze,
  input logic                     sat_hit,
  input logic                     out_valid,
  input logic signed [DATA_W-1:0] out_data,
  input logic signed [DATA_W-1:0] offset_left,
  input logic signed [DATA_W-1:0] offset_right
);
  localparam logic signed [DATA_W-1:0] MAXV = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic signed [DATA_W-1:0] MINV = {1'b1, {(DATA_W-1){1'b0}}};

  // R2
  strobe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R2
  idle_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R6
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && freeze) |=> ($stable(offset_left) && $stable(offset_right)));

  // R5
  left_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_chan) |=> $stable(offset_right));

  // R5
  right_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_chan) |=> $stable(offset_left));

  // R9
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(offset_left) && $stable(offset_right)));

  // R8
  clip_rail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sat_hit) |=> (out_data == MAXV || out_data == MINV));
endmodule

bind dct_trim_filter dct_checker #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_chan     (in_chan),
  .freeze      (freeze),
  .sat_hit     (sat_hit),
  .out_valid   (out_valid),
  .out_data    (out_data),
  .offset_left (offset_left),
  .offset_right(offset_right)
);

// File: tb/dct_trim_filter_test.sv
module dct_trim_filter_test;
  localparam int  DW   = 24;
  localparam int  TK   = 4;
  localparam longint MAXV = (longint'(1) <<< (DW - 1)) - 1;
  localparam longint MINV = -(longint'(1) <<< (DW - 1));

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_chan = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          freeze = 1'b0;
  logic          out_valid;
  logic          out_chan;
  logic [DW-1:0] out_data;
  logic [DW-1:0] offset_left;
  logic [DW-1:0] offset_right;

  int n_chk = 0;
  int n_bad = 0;
  longint accm [2];

  always #2 clk = ~clk;

  dct_trim_filter #(.DATA_W(DW), .SHIFT_K(TK)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_chan(in_chan),
    .in_data(in_data), .freeze(freeze), .out_valid(out_valid),
    .out_chan(out_chan), .out_data(out_data),
    .offset_left(offset_left), .offset_right(offset_right));

  function automatic longint sx(input logic [DW-1:0] d);
    return longint'($signed(d));
  endfunction

  function automatic longint est_of(input longint a);
    return a >>> TK;
  endfunction

  function automatic longint clamp(input longint v);
    if (v > MAXV) return MAXV;
    if (v < MINV) return MINV;
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Drive one strobed sample at a falling edge, check at the next falling edge.
  task automatic send(input bit ch, input longint x, input bit frz);
    longint diff, expo, err;
    in_valid = 1'b1;
    in_chan  = ch;
    in_data  = x[DW-1:0];
    freeze   = frz;
    diff = x - est_of(accm[ch]);
    expo = clamp(diff);
    if (!frz) begin
      err = (x <<< TK) - accm[ch];
      accm[ch] = accm[ch] + (err >>> TK);
    end
    @(negedge clk);
    chk(out_valid == 1'b1, "R2 valid", longint'(out_valid), 1);
    chk(out_chan == ch, "R2 chan", longint'(out_chan), longint'(ch));
    if (expo != diff)
      chk(sx(out_data) == expo, "R8 clip", sx(out_data), expo);
    else if (frz)
      chk(sx(out_data) == expo, "R7 held subtract", sx(out_data), expo);
    else
      chk(sx(out_data) == expo, "R3 subtract", sx(out_data), expo);
    if (frz) begin
      chk(sx(offset_left) == est_of(accm[0]), "R6 left held", sx(offset_left), est_of(accm[0]));
      chk(sx(offset_right) == est_of(accm[1]), "R6 right held", sx(offset_right), est_of(accm[1]));
    end else if (ch) begin
      chk(sx(offset_right) == est_of(accm[1]), "R4 right update", sx(offset_right), est_of(accm[1]));
      chk(sx(offset_left) == est_of(accm[0]), "R5 left untouched", sx(offset_left), est_of(accm[0]));
    end else begin
      chk(sx(offset_left) == est_of(accm[0]), "R4 left update", sx(offset_left), est_of(accm[0]));
      chk(sx(offset_right) == est_of(accm[1]), "R5 right untouched", sx(offset_right), est_of(accm[1]));
    end
  endtask

  task automatic idle(input bit frz);
    in_valid = 1'b0;
    freeze   = frz;
    in_data  = DW'($urandom);
    @(negedge clk);
    chk(out_valid == 1'b0, "R2 idle", longint'(out_valid), 0);
    chk(sx(offset_left) == est_of(accm[0]), "R9 left idle", sx(offset_left), est_of(accm[0]));
    chk(sx(offset_right) == est_of(accm[1]), "R9 right idle", sx(offset_right), est_of(accm[1]));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0dc1));
    accm[0] = 0;
    accm[1] = 0;
    repeat (4) @(negedge clk);
    // R1: state during reset
    chk(out_valid == 1'b0, "R1 valid in reset", longint'(out_valid), 0);
    chk(sx(offset_left) == 0, "R1 left in reset", sx(offset_left), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 valid after reset", longint'(out_valid), 0);
    chk(sx(out_data) == 0, "R1 data after reset", sx(out_data), 0);
    chk(sx(offset_left) == 0, "R1 left after reset", sx(offset_left), 0);
    chk(sx(offset_right) == 0, "R1 right after reset", sx(offset_right), 0);

    // directed: first samples, alternate tags, idle gap
    send(1'b0, 1000, 1'b0);
    send(1'b1, -5000, 1'b0);
    send(1'b0, 1000, 1'b0);
    idle(1'b0);
    idle(1'b1);
    send(1'b1, 77, 1'b0);

    // R6 / R7: held estimates keep being subtracted
    for (int i = 0; i < 6; i++) send(i[0], 40000 + i * 3, 1'b1);
    idle(1'b0);

    // R10: settle left on a constant, then check the residue
    for (int i = 0; i < 600; i++) send(1'b0, 300000, 1'b0);
    send(1'b0, 300000, 1'b1);
    chk(sx(out_data) == 0 || sx(out_data) == 1, "R10 settled residue", sx(out_data), 0);

    // R8: estimate near the top, then the most negative sample
    for (int i = 0; i < 600; i++) send(1'b0, MAXV, 1'b0);
    send(1'b0, MINV, 1'b1);
    chk(sx(out_data) == MINV, "R8 low rail", sx(out_data), MINV);
    // estimate near the bottom, then the most positive sample
    for (int i = 0; i < 600; i++) send(1'b1, MINV, 1'b0);
    send(1'b1, MAXV, 1'b0);
    chk(sx(out_data) == MAXV, "R8 high rail", sx(out_data), MAXV);

    // constrained random mix
    for (int i = 0; i < 1500; i++) begin
      int unsigned pick;
      longint x;
      pick = $urandom_range(0, 19);
      if (pick == 0)      x = MAXV;
      else if (pick == 1) x = MINV;
      else if (pick < 8)  x = longint'($signed(16'($urandom)));
      else                x = sx(DW'($urandom));
      if ($urandom_range(0, 9) == 0) idle($urandom_range(0, 1) == 1);
      send($urandom_range(0, 1) == 1, x, $urandom_range(0, 9) == 0);
    end
    idle(1'b0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule